// File: doc/BRIEF.md
# Staged Low-Activity Content Addressable Memory

This block is a small associative store. Software-facing logic writes words into numbered entries, each with a valid flag. A search then presents a key and gets back, one cycle later, a vector of the entries that hold exactly that key, a hit flag, and the number of the lowest matching entry.

To keep switching activity low, each entry decides its match in stages. When a word is written, the block also stores how many 1 bits it has. During a search, an entry whose stored ones-count differs from the key's ones-count is filtered out at once. Alongside that filter, a short leading segment of the word (the top `PREFIX` bits) is compared as a chained segment. The wider trailing segment of an entry is enabled only when both of these front checks pass.

For every search the block also reports three activity counts: how many entries passed the ones-count filter, how many passed the leading segment, and how many had their trailing segment enabled. Match indications follow a two-phase pattern. Each is preset to "match" and then cleared by any disagreeing bit.

Top module: `staged_cam`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` and `wr_valid` into entry `wr_idx`, and the next search sees the new contents.
- R2: `rsp_cnt_pop` equals the number of valid entries whose stored ones-count equals the ones-count of the search key.
- R3: `rsp_cnt_pre` equals the number of valid entries whose top `PREFIX` bits equal the top `PREFIX` bits of the key.
- R4: An entry's trailing segment is enabled only when it passes both the ones-count filter and the leading segment. `rsp_cnt_tail` counts exactly those entries, so it never exceeds either of the other two counts.
- R5: `rsp_match[i]` is 1 exactly when entry i is valid and its stored word equals the key in all `WIDTH` bits.
- R6: `rsp_hit` is the OR of `rsp_match`. `rsp_idx` is the smallest i with `rsp_match[i]` set, and 0 when there is no hit.
- R7: The response is registered. `rsp_valid` is high in exactly the cycle after a cycle with `srch_req` high. In a cycle with `rsp_valid` low, all other response outputs are 0.
- R8: An entry with its valid flag clear never matches and is never counted at any stage, whatever data it holds.
- R9: When a write and a search happen in the same cycle, that search is judged against the contents as they were before the write.
- R10: After reset, every entry is invalid and all response outputs are 0.
- R11: With `PREFIX` = 0, every valid entry counts as passing the leading segment, and every entry that passes the ones-count filter has its trailing segment enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry written |
| wr_data | input | WIDTH | Word written |
| wr_valid | input | 1 | Valid flag written with the word |
| srch_req | input | 1 | Search request |
| srch_key | input | WIDTH | Search key |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_match | output | DEPTH | Per-entry match vector |
| rsp_hit | output | 1 | Any entry matched |
| rsp_idx | output | IDX_W | Lowest matching entry |
| rsp_cnt_pop | output | ACT_W | Entries passing the ones-count filter |
| rsp_cnt_pre | output | ACT_W | Entries passing the leading segment |
| rsp_cnt_tail | output | ACT_W | Entries with trailing segment enabled |

## Verification
A write and a search can land in the same cycle, including on the entry the search would hit. The bench provokes this by driving both strobes together, with a key equal to the entry's old word while new data goes in. It judges the response against the model as it stood before the write, and then searches again to confirm the new word has taken effect. All 64 keys of a 6-bit configuration are swept over two table loads that contain duplicates and invalid entries. The sweep is run on a two-bit-prefix instance and on a zero-prefix instance.

// File: rtl/staged_cam_pkg.sv
package staged_cam_pkg;

    localparam int MAX_W = 64;

    // Number of 1 bits in a word of up to MAX_W bits.
    function automatic logic [6:0] ones_of(input logic [MAX_W-1:0] v);
        logic [6:0] n;
        n = '0;
        for (int b = 0; b < MAX_W; b++) begin
            n = n + 7'(v[b]);
        end
        return n;
    endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int WIDTH = 6,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         wr_valid,
    output logic [DEPTH-1:0][WIDTH-1:0]  ent_data,
    output logic [DEPTH-1:0]             ent_valid,
    output logic [DEPTH-1:0][CNT_W-1:0]  ent_ones
);
    import staged_cam_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] data;
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0][CNT_W-1:0] ones;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < DEPTH)) begin
            st_d.data[wr_idx]  = wr_data;
            st_d.valid[wr_idx] = wr_valid;
            // ones-count kept beside the word, refreshed on the same write
            st_d.ones[wr_idx]  = CNT_W'(ones_of(MAX_W'(wr_data)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_data  = st_q.data;
    assign ent_valid = st_q.valid;
    assign ent_ones  = st_q.ones;

endmodule

// File: rtl/cam_entry_cmp.sv
module cam_entry_cmp #(
    parameter int WIDTH  = 6,
    parameter int PREFIX = 2,
    parameter int CNT_W  = 3
) (
    input  logic [WIDTH-1:0] ent_data,
    input  logic             ent_valid,
    input  logic [CNT_W-1:0] ent_ones,
    input  logic [WIDTH-1:0] key,
    input  logic [CNT_W-1:0] key_ones,
    output logic             pop_ok,
    output logic             pre_ok,
    output logic             tail_en,
    output logic             hit
);
    localparam int TAIL_W = WIDTH - PREFIX;

    logic pre_seg;
    logic tail_seg;

    // leading segment: all PREFIX bits must agree
    if (PREFIX == 0) begin : g_no_pre
        assign pre_seg = 1'b1;
    end else begin : g_pre
        assign pre_seg = (ent_data[WIDTH-1 -: PREFIX] == key[WIDTH-1 -: PREFIX]);
    end

    // trailing segment: the remaining bits
    if (TAIL_W == 0) begin : g_no_tail
        assign tail_seg = 1'b1;
    end else begin : g_tail
        assign tail_seg = (ent_data[TAIL_W-1:0] == key[TAIL_W-1:0]);
    end

    always_comb begin
        // precharge phase: lines start as "match"
        pop_ok  = 1'b1;
        pre_ok  = 1'b1;
        // evaluate phase: any disagreement clears
        if (!ent_valid || (ent_ones != key_ones)) pop_ok = 1'b0;
        if (!ent_valid || !pre_seg)               pre_ok = 1'b0;
        tail_en = pop_ok && pre_ok;
        hit     = tail_en;
        if (tail_en && !tail_seg) hit = 1'b0;
    end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/staged_cam.sv
module staged_cam #(
    parameter int WIDTH  = 6,
    parameter int DEPTH  = 8,
    parameter int PREFIX = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(WIDTH + 1),
    localparam int ACT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             srch_req,
    input  logic [WIDTH-1:0] srch_key,
    output logic             rsp_valid,
    output logic [DEPTH-1:0] rsp_match,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [ACT_W-1:0] rsp_cnt_pop,
    output logic [ACT_W-1:0] rsp_cnt_pre,
    output logic [ACT_W-1:0] rsp_cnt_tail
);
    import staged_cam_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [DEPTH-1:0] match;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [ACT_W-1:0] cnt_pop;
        logic [ACT_W-1:0] cnt_pre;
        logic [ACT_W-1:0] cnt_tail;
    } rsp_t;

    logic [DEPTH-1:0][WIDTH-1:0] ent_data;
    logic [DEPTH-1:0]            ent_valid;
    logic [DEPTH-1:0][CNT_W-1:0] ent_ones;
    logic [CNT_W-1:0]            key_ones;
    logic [DEPTH-1:0]            pop_ok, pre_ok, tail_en, ent_hit;
    logic                        any_hit;
    logic [IDX_W-1:0]            low_idx;
    rsp_t                        rsp_d, rsp_q;

    cam_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .ent_data (ent_data),
        .ent_valid(ent_valid),
        .ent_ones (ent_ones)
    );

    assign key_ones = CNT_W'(ones_of(MAX_W'(srch_key)));

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        cam_entry_cmp #(.WIDTH(WIDTH), .PREFIX(PREFIX), .CNT_W(CNT_W)) u_cmp (
            .ent_data (ent_data[e]),
            .ent_valid(ent_valid[e]),
            .ent_ones (ent_ones[e]),
            .key      (srch_key),
            .key_ones (key_ones),
            .pop_ok   (pop_ok[e]),
            .pre_ok   (pre_ok[e]),
            .tail_en  (tail_en[e]),
            .hit      (ent_hit[e])
        );
    end

    cam_prio_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_prio (
        .vec(ent_hit),
        .any(any_hit),
        .idx(low_idx)
    );

    always_comb begin
        rsp_d = '0;
        if (srch_req) begin
            rsp_d.valid = 1'b1;
            rsp_d.match = ent_hit;
            rsp_d.hit   = any_hit;
            rsp_d.idx   = low_idx;
            for (int i = 0; i < DEPTH; i++) begin
                rsp_d.cnt_pop  = rsp_d.cnt_pop  + ACT_W'(pop_ok[i]);
                rsp_d.cnt_pre  = rsp_d.cnt_pre  + ACT_W'(pre_ok[i]);
                rsp_d.cnt_tail = rsp_d.cnt_tail + ACT_W'(tail_en[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_match    = rsp_q.match;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_idx      = rsp_q.idx;
    assign rsp_cnt_pop  = rsp_q.cnt_pop;
    assign rsp_cnt_pre  = rsp_q.cnt_pre;
    assign rsp_cnt_tail = rsp_q.cnt_tail;

endmodule

// File: rtl/staged_cam_chk.sv
module staged_cam_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int ACT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_req,
    input logic             rsp_valid,
    input logic [DEPTH-1:0] rsp_match,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [ACT_W-1:0] rsp_cnt_pop,
    input logic [ACT_W-1:0] rsp_cnt_pre,
    input logic [ACT_W-1:0] rsp_cnt_tail
);
    logic [DEPTH-1:0] below_mask;
    assign below_mask = (DEPTH'(1) << rsp_idx) - DEPTH'(1);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(srch_req)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_match == '0 && !rsp_hit && rsp_idx == '0 &&
                        rsp_cnt_pop == '0 && rsp_cnt_pre == '0 && rsp_cnt_tail == '0)); // R7

    AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit == (|rsp_match)); // R6

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_match[rsp_idx] && ((rsp_match & below_mask) == '0))); // R6

    AST_TAIL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_cnt_tail <= rsp_cnt_pop) && (rsp_cnt_tail <= rsp_cnt_pre)); // R4

    AST_MATCH_WITHIN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rsp_match) <= int'(rsp_cnt_tail)); // R5

endmodule

bind staged_cam staged_cam_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ACT_W(ACT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .srch_req    (srch_req),
    .rsp_valid   (rsp_valid),
    .rsp_match   (rsp_match),
    .rsp_hit     (rsp_hit),
    .rsp_idx     (rsp_idx),
    .rsp_cnt_pop (rsp_cnt_pop),
    .rsp_cnt_pre (rsp_cnt_pre),
    .rsp_cnt_tail(rsp_cnt_tail)
);

// File: tb/staged_cam_tb.sv
module staged_cam_tb;
    localparam int W  = 6;
    localparam int D  = 8;
    localparam int K  = 2;
    localparam int IW = 3;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          srch_req = 1'b0;
    logic [W-1:0]  srch_key = '0;

    logic          a_valid, a_hit, b_valid, b_hit;
    logic [D-1:0]  a_match, b_match;
    logic [IW-1:0] a_idx, b_idx;
    logic [AW-1:0] a_pop, a_pre, a_tail, b_pop, b_pre, b_tail;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] m_data [D];
    logic         m_val  [D];

    always #10 clk = ~clk;

    staged_cam #(.WIDTH(W), .DEPTH(D), .PREFIX(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_valid(wr_valid), .srch_req(srch_req), .srch_key(srch_key),
        .rsp_valid(a_valid), .rsp_match(a_match), .rsp_hit(a_hit), .rsp_idx(a_idx),
        .rsp_cnt_pop(a_pop), .rsp_cnt_pre(a_pre), .rsp_cnt_tail(a_tail)
    );

    staged_cam #(.WIDTH(W), .DEPTH(D), .PREFIX(0)) u_dut_k0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_valid(wr_valid), .srch_req(srch_req), .srch_key(srch_key),
        .rsp_valid(b_valid), .rsp_match(b_match), .rsp_hit(b_hit), .rsp_idx(b_idx),
        .rsp_cnt_pop(b_pop), .rsp_cnt_pre(b_pre), .rsp_cnt_tail(b_tail)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary();
        $finish;
    end

    // expected response for prefix length k, from the model table
    task automatic expect_for(input int key, input int k, output logic [D-1:0] m,
                              output logic hit, output int idx,
                              output int pop, output int pre, output int tail);
        m = '0; pop = 0; pre = 0; tail = 0; idx = 0; hit = 1'b0;
        for (int i = 0; i < D; i++) begin
            if (m_val[i]) begin
                int d;
                logic p1, p2;
                d  = int'(m_data[i]);
                p1 = ($countones(d) == $countones(key));
                p2 = ((d >> (W - k)) == (key >> (W - k)));
                if (p1) pop++;
                if (p2) pre++;
                if (p1 && p2) tail++;
                if (d == key) m[i] = 1'b1;
            end
        end
        for (int i = D - 1; i >= 0; i--) if (m[i]) begin idx = i; hit = 1'b1; end
    endtask

    task automatic compare(input string tag, input int key, input int k, input logic v,
                           input logic [D-1:0] am, input logic ah, input logic [IW-1:0] ai,
                           input logic [AW-1:0] ap, input logic [AW-1:0] ar,
                           input logic [AW-1:0] at);
        logic [D-1:0] em;
        logic eh;
        int ei, ep, er, et;
        expect_for(key, k, em, eh, ei, ep, er, et);
        checks++;
        if (!v || am !== em || ah !== eh || int'(ai) != ei ||
            int'(ap) != ep || int'(ar) != er || int'(at) != et) begin
            failures++;
            $display("FAIL %s k=%0d key=%0d: actual v=%b m=%b h=%b i=%0d pop=%0d pre=%0d tail=%0d expected v=1 m=%b h=%b i=%0d pop=%0d pre=%0d tail=%0d",
                     tag, k, key, v, am, ah, ai, ap, ar, at, em, eh, ei, ep, er, et);
        end
    endtask

    task automatic check_both(input string tag, input int key);
        compare({tag, " R2 R3 R4 R5 R6 R8"}, key, K, a_valid, a_match, a_hit, a_idx, a_pop, a_pre, a_tail);
        compare({tag, " R11"}, key, 0, b_valid, b_match, b_hit, b_idx, b_pop, b_pre, b_tail);
    endtask

    task automatic check_idle();
        checks++;
        if (a_valid || a_match != '0 || a_hit || a_pop != '0 || a_pre != '0 || a_tail != '0 ||
            b_valid || b_match != '0) begin
            failures++;
            $display("FAIL R7 idle: actual v=%b m=%b pop=%0d expected v=0 m=0 pop=0",
                     a_valid, a_match, a_pop);
        end
    endtask

    task automatic do_write(input int idx, input int data, input logic vld);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = W'(data); wr_valid = vld;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[idx] = W'(data);
        m_val[idx]  = vld;
    endtask

    task automatic do_search(input string tag, input int key);
        @(negedge clk);
        srch_req = 1'b1; srch_key = W'(key);
        @(negedge clk);
        srch_req = 1'b0;
        check_both(tag, key);
        @(negedge clk);
        check_idle();  // R7: pulse lasts one cycle
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin m_data[i] = '0; m_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of outputs
        checks++;
        if (a_valid || a_match != '0 || a_hit || a_idx != '0 || a_tail != '0) begin
            failures++;
            $display("FAIL R10 reset outputs: actual v=%b m=%b expected v=0 m=0", a_valid, a_match);
        end
        // R10: table empty after reset, key 0 would match all-zero data if valid
        do_search("R10 empty", 0);

        // load A: duplicates (2 and 6), an invalid slot holding data (3)
        for (int i = 0; i < D; i++) do_write(i, (i * 13 + 5) & 63, 1'b1);
        do_write(6, (2 * 13 + 5) & 63, 1'b1);
        do_write(3, 45, 1'b0);
        for (int key = 0; key < 64; key++) do_search("R1 loadA", key);

        // load B: all valid, many sharing ones-counts and prefixes
        for (int i = 0; i < D; i++) do_write(i, ((i * 7) ^ 9) & 63, 1'b1);
        do_write(5, ((1 * 7) ^ 9) & 63, 1'b1);
        for (int key = 0; key < 64; key++) do_search("R1 loadB", key);

        // R8: invalidate an entry holding the key
        do_write(4, 33, 1'b0);
        do_search("R8 invalid", 33);

        // R9: write and search in the same cycle on the hit entry
        do_write(0, 21, 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = '0; wr_data = W'(42); wr_valid = 1'b1;
        srch_req = 1'b1; srch_key = W'(21);
        @(negedge clk);
        wr_en = 1'b0; srch_req = 1'b0;
        check_both("R9 same-cycle old", 21);
        m_data[0] = W'(42);
        do_search("R9 after old", 21);
        do_search("R9 after new", 42);

        summary();
        $finish;
    end
endmodule